// File: doc/BRIEF.md
# Permission-Merging Translation Cache

The block holds recent address translations. Each entry maps one page number to one physical frame. A page-walk engine sends each finished walk to the fill port. The fill carries the final frame and, for each of the four walk levels, the present, reserved, accessed, write, user and execute-disable bits. It also carries the dirty bit and the memory type of the entry that maps the frame. The block folds the per-level bits into a single set of rights and decides whether the walk may be cached. When a walk is refused only because some accessed bits are still clear, the block raises a request for each of those levels so the walker can set them and send the walk again.

Lookup is a plain combinational port: a page number goes in, and hit, frame and rights come out in the same cycle. Invalidation removes one page number or every entry. A client may never assume that a translation it filled is still held.

The fill port uses valid/ready. A fill is taken on a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` falls only in a cycle that carries an invalidate which would cancel that fill: a flush-all, or a single invalidate of the same page number. The walker must then hold the fill stable and offer it again. A taken fill that fails the walk checks is dropped, and `fill_refused` reports that in the same cycle.

Top module: `tlb_cache`

## Requirements
- R1: Once a fill has been accepted, a lookup of that page number gives `lk_hit`=1 and the stored frame in the same cycle. A page number that is not held gives `lk_hit`=0.
- R2: The stored write right is the AND of `fill_rw` over the used levels. The stored user right is the AND of `fill_us` over the used levels.
- R3: The stored execute-disable bit is the OR of `fill_xd` over the used levels when `nxe_en`=1 at fill time, and 0 when `nxe_en`=0.
- R4: `fill_leaf_lvl` is the index of the level that maps the frame. Bit 0 of each per-level vector is the top level, and the used levels are indices 0 through `fill_leaf_lvl`. Bits above the leaf level have no effect. The stored dirty bit and memory type are `fill_dirty` and `fill_mtype`.
- R5: A fill is refused, and no entry changes, if any used level has present=0 or reserved=1. In that case `acc_set_req` stays 0.
- R6: A fill whose used levels are all present with no reserved bits, but which has some used accessed bit equal to 0, is refused. During that fill cycle `acc_set_req` shows 1 for exactly those levels.
- R7: A fill for a page number that is already held overwrites that entry in place, and no other entry is lost.
- R8: A fill goes into the lowest-index empty slot if one exists. When all 8 slots are valid, it replaces the slot under a round-robin pointer. The pointer starts at 0 and advances only on such a replacement.
- R9: A single invalidate removes only the matching page number. A flush-all removes every entry.
- R10: An invalidate in the same cycle as a fill wins when it is a flush-all or names the fill's page number: `fill_ready`=0 and the fill is not written. An invalidate of a different page does not block the fill.
- R11: Synchronous active-high reset empties every entry and sets the round-robin pointer to 0.
- R12: A fill takes effect at the next clock edge. A lookup during the fill cycle still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxe_en | input | 1 | Enables the execute-disable merge |
| fill_valid | input | 1 | Walk result offered |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vpn | input | 36 | Page number of the walk |
| fill_pfn | input | 40 | Final frame |
| fill_leaf_lvl | input | 2 | Index of the level mapping the frame |
| fill_present | input | 4 | Per-level present bits |
| fill_rsvd | input | 4 | Per-level reserved-bit violation |
| fill_accessed | input | 4 | Per-level accessed bits |
| fill_rw | input | 4 | Per-level write permission |
| fill_us | input | 4 | Per-level user permission |
| fill_xd | input | 4 | Per-level execute-disable |
| fill_dirty | input | 1 | Dirty bit of the final entry |
| fill_mtype | input | 3 | Memory type of the final entry |
| fill_refused | output | 1 | Taken fill failed the caching checks |
| acc_set_req | output | 4 | Levels whose accessed bit must be set |
| inv_valid | input | 1 | Invalidate request |
| inv_all | input | 1 | 1 = flush all, 0 = single page |
| inv_vpn | input | 36 | Page number to invalidate |
| lk_vpn | input | 36 | Lookup page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 40 | Frame of the hit entry |
| lk_write | output | 1 | Merged write right |
| lk_user | output | 1 | Merged user right |
| lk_xd | output | 1 | Merged execute-disable |
| lk_dirty | output | 1 | Stored dirty bit |
| lk_mtype | output | 3 | Stored memory type |

## Verification
Fill and invalidate are the two functions that can land on the same clock edge. The bench provokes this by raising `fill_valid` and `inv_valid` in one cycle in three ways: an invalidate of the same page, an invalidate of a different held page, and a flush-all. Each case is judged on `fill_ready` before the edge and on later lookups of both page numbers. The fill must be lost in the first and last cases. In the middle case the fill must land while the other page disappears.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VPN_W   = 36;
  localparam int unsigned DEF_PFN_W   = 40;
  localparam int unsigned DEF_LEVELS  = 4;
  localparam int unsigned DEF_MT_W    = 3;

  // rights and attributes folded from one page walk
  typedef struct packed {
    logic wr;
    logic usr;
    logic xd;
    logic dirty;
  } tlb_rights_t;
endpackage

// File: rtl/tlb_walk_merge.sv
module tlb_walk_merge
  import tlb_pkg::*;
#(
  parameter int unsigned LEVELS = DEF_LEVELS,
  parameter int unsigned LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              nxe,
  input  logic [LVL_W-1:0]  leaf,
  input  logic [LEVELS-1:0] present,
  input  logic [LEVELS-1:0] rsvd,
  input  logic [LEVELS-1:0] accessed,
  input  logic [LEVELS-1:0] rw,
  input  logic [LEVELS-1:0] us,
  input  logic [LEVELS-1:0] xd,
  input  logic              dirty,
  output tlb_rights_t       rights,
  output logic              cacheable,
  output logic [LEVELS-1:0] acc_req
);
  logic [LEVELS-1:0] used;
  logic walk_ok, all_acc;

  // levels 0..leaf take part in the translation
  for (genvar g = 0; g < LEVELS; g++) begin : g_used
    assign used[g] = (32'(g) <= 32'(leaf));
  end

  always_comb begin
    walk_ok      = (&(present | ~used)) && !(|(rsvd & used));
    all_acc      = &(accessed | ~used);
    cacheable    = walk_ok && all_acc;
    acc_req      = (fire && walk_ok) ? (used & ~accessed) : '0;
    rights.wr    = &(rw | ~used);
    rights.usr   = &(us | ~used);
    rights.xd    = nxe && (|(xd & used));
    rights.dirty = dirty;
  end

  p_acc_req_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (|acc_req) |-> !cacheable);
  p_bad_walk_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && !(&(present | ~used))) |-> (acc_req == '0));
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic             advance,
  output logic [IDX_W-1:0] slot,
  output logic             full
);
  logic [IDX_W-1:0] ptr_q, free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IDX_W'(i);
    full = &valid;
    slot = full ? ptr_q : free_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr_q));
  p_adv_only_full_r8: assert property (@(posedge clk) disable iff (rst)
    advance |-> full);
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int unsigned N     = DEF_ENTRIES,
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PFN_W = DEF_PFN_W,
  parameter int unsigned MT_W  = DEF_MT_W,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  tlb_rights_t      wr_rights,
  input  logic [MT_W-1:0]  wr_mtype,
  input  logic             inv_valid,
  input  logic             inv_all,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output tlb_rights_t      lk_rights,
  output logic [MT_W-1:0]  lk_mtype
);
  logic [N-1:0]     valid_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  tlb_rights_t      rts_q [N];
  logic [MT_W-1:0]  mt_q  [N];

  logic [N-1:0]     lk_match, wr_match, inv_match;
  logic             wr_hit, vic_full, advance;
  logic [IDX_W-1:0] wr_hit_idx, vic_slot, wr_slot;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_match[g]  = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign wr_match[g]  = valid_q[g] && (vpn_q[g] == wr_vpn);
    assign inv_match[g] = valid_q[g] && (vpn_q[g] == inv_vpn);
  end

  always_comb begin
    wr_hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (wr_match[i]) wr_hit_idx = IDX_W'(i);
    wr_hit  = |wr_match;
    advance = wr_en && !wr_hit && vic_full;
    wr_slot = wr_hit ? wr_hit_idx : vic_slot;
  end

  tlb_victim_pick #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid_q),
    .advance (advance),
    .slot    (vic_slot),
    .full    (vic_full)
  );

  // a written slot never holds the invalidated page (guarded at the top)
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && (wr_slot == IDX_W'(i))) valid_q[i] <= 1'b1;
        else if (inv_valid && (inv_all || inv_match[i])) valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_slot] <= wr_vpn;
      pfn_q[wr_slot] <= wr_pfn;
      rts_q[wr_slot] <= wr_rights;
      mt_q[wr_slot]  <= wr_mtype;
    end
  end

  always_comb begin
    lk_pfn    = '0;
    lk_rights = '0;
    lk_mtype  = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_pfn    = lk_pfn | pfn_q[i];
        lk_rights = tlb_rights_t'(lk_rights | rts_q[i]);
        lk_mtype  = lk_mtype | mt_q[i];
      end
    end
    lk_hit = |lk_match;
  end

  p_one_match_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match) && $onehot0(wr_match));
  p_inv_beats_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && inv_valid) |-> !(inv_all || (inv_vpn == wr_vpn)));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_all) |=> (valid_q == '0));
  p_idle_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !inv_valid) |=> $stable(valid_q));
  p_fill_lands_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_q != '0));
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_ENTRIES,
  parameter int unsigned VPN_W     = DEF_VPN_W,
  parameter int unsigned PFN_W     = DEF_PFN_W,
  parameter int unsigned LEVELS    = DEF_LEVELS,
  parameter int unsigned MT_W      = DEF_MT_W,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int unsigned LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxe_en,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [LVL_W-1:0]  fill_leaf_lvl,
  input  logic [LEVELS-1:0] fill_present,
  input  logic [LEVELS-1:0] fill_rsvd,
  input  logic [LEVELS-1:0] fill_accessed,
  input  logic [LEVELS-1:0] fill_rw,
  input  logic [LEVELS-1:0] fill_us,
  input  logic [LEVELS-1:0] fill_xd,
  input  logic              fill_dirty,
  input  logic [MT_W-1:0]   fill_mtype,
  output logic              fill_refused,
  output logic [LEVELS-1:0] acc_set_req,
  input  logic              inv_valid,
  input  logic              inv_all,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_write,
  output logic              lk_user,
  output logic              lk_xd,
  output logic              lk_dirty,
  output logic [MT_W-1:0]   lk_mtype
);
  tlb_rights_t merged, lk_rights;
  logic fire, cacheable, wr_en;

  // an invalidate that would cancel this fill holds it off
  assign fill_ready   = !(inv_valid && (inv_all || (inv_vpn == fill_vpn)));
  assign fire         = fill_valid && fill_ready;
  assign wr_en        = fire && cacheable;
  assign fill_refused = fire && !cacheable;

  tlb_walk_merge #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .nxe       (nxe_en),
    .leaf      (fill_leaf_lvl),
    .present   (fill_present),
    .rsvd      (fill_rsvd),
    .accessed  (fill_accessed),
    .rw        (fill_rw),
    .us        (fill_us),
    .xd        (fill_xd),
    .dirty     (fill_dirty),
    .rights    (merged),
    .cacheable (cacheable),
    .acc_req   (acc_set_req)
  );

  tlb_entry_store #(
    .N(N_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .MT_W(MT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_vpn    (fill_vpn),
    .wr_pfn    (fill_pfn),
    .wr_rights (merged),
    .wr_mtype  (fill_mtype),
    .inv_valid (inv_valid),
    .inv_all   (inv_all),
    .inv_vpn   (inv_vpn),
    .lk_vpn    (lk_vpn),
    .lk_hit    (lk_hit),
    .lk_pfn    (lk_pfn),
    .lk_rights (lk_rights),
    .lk_mtype  (lk_mtype)
  );

  assign lk_write = lk_rights.wr;
  assign lk_user  = lk_rights.usr;
  assign lk_xd    = lk_rights.xd;
  assign lk_dirty = lk_rights.dirty;

  p_refused_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    fill_refused |-> !wr_en);
endmodule

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
  logic clk = 1'b0, rst = 1'b1, nxe_en = 1'b0;
  logic fill_valid = 1'b0, fill_ready, fill_refused;
  logic [35:0] fill_vpn = '0, inv_vpn = '0, lk_vpn = '0;
  logic [39:0] fill_pfn = '0, lk_pfn;
  logic [1:0]  fill_leaf_lvl = 2'd3;
  logic [3:0]  fill_present = '0, fill_rsvd = '0, fill_accessed = '0;
  logic [3:0]  fill_rw = '0, fill_us = '0, fill_xd = '0, acc_set_req;
  logic        fill_dirty = 1'b0, inv_valid = 1'b0, inv_all = 1'b0;
  logic [2:0]  fill_mtype = '0, lk_mtype;
  logic        lk_hit, lk_write, lk_user, lk_xd, lk_dirty;

  int n_chk = 0, n_err = 0;
  logic pre_hit, pre_ready, pre_refused;
  logic [3:0] pre_acc;

  always #4 clk = ~clk;

  tlb_cache dut (.*);

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [35:0] v, input logic h, input logic [39:0] p, input string req);
    lk_vpn = v;
    #1;
    eq(req, 64'(lk_hit), 64'(h));
    if (h) eq(req, 64'(lk_pfn), 64'(p));
  endtask

  task automatic prep(input logic [35:0] v, input logic [39:0] p);
    fill_vpn = v; fill_pfn = p; fill_leaf_lvl = 2'd3;
    fill_present = 4'hF; fill_rsvd = 4'h0; fill_accessed = 4'hF;
    fill_rw = 4'hF; fill_us = 4'hF; fill_xd = 4'h0;
    fill_dirty = 1'b0; fill_mtype = 3'd0;
  endtask

  task automatic fire_fill();
    @(negedge clk);
    fill_valid = 1'b1; lk_vpn = fill_vpn;
    #1;
    pre_hit = lk_hit; pre_ready = fill_ready;
    pre_refused = fill_refused; pre_acc = acc_set_req;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv(input logic all, input logic [35:0] v);
    @(negedge clk);
    inv_valid = 1'b1; inv_all = all; inv_vpn = v;
    @(negedge clk);
    inv_valid = 1'b0; inv_all = 1'b0;
  endtask

  task automatic collide(input logic all, input logic [35:0] v);
    @(negedge clk);
    inv_valid = 1'b1; inv_all = all; inv_vpn = v; fill_valid = 1'b1;
    #1;
    pre_ready = fill_ready;
    @(posedge clk);
    @(negedge clk);
    inv_valid = 1'b0; inv_all = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    look(36'h0, 1'b0, '0, "R11 empty after reset");
    look(36'h123, 1'b0, '0, "R11 empty after reset");
    eq("R11 ready idle", 64'(fill_ready), 64'd1);
    eq("R6 no acc req idle", 64'(acc_set_req), 64'd0);
  endtask

  task automatic t_basic();
    prep(36'h123, 40'hABCDE);
    fire_fill();
    eq("R12 miss during fill cycle", 64'(pre_hit), 64'd0);
    look(36'h123, 1'b1, 40'hABCDE, "R1 hit frame");
    eq("R2 write all ones", 64'(lk_write), 64'd1);
    eq("R2 user all ones", 64'(lk_user), 64'd1);
    look(36'h124, 1'b0, '0, "R1 other page misses");
  endtask

  task automatic t_merge();
    do_inv(1'b1, '0);
    prep(36'h200, 40'h11); fill_rw = 4'b1011;
    fire_fill();
    look(36'h200, 1'b1, 40'h11, "R2 fill taken");
    eq("R2 write AND", 64'(lk_write), 64'd0);
    eq("R2 user AND", 64'(lk_user), 64'd1);
    prep(36'h201, 40'h12); fill_us = 4'b0111;
    fire_fill();
    look(36'h201, 1'b1, 40'h12, "R2 fill taken");
    eq("R2 user leaf zero", 64'(lk_user), 64'd0);
    // leaf at level 1: upper bits are junk and must not matter
    prep(36'h202, 40'h13); fill_leaf_lvl = 2'd1;
    fill_rw = 4'b0011; fill_us = 4'b0011; fill_present = 4'b0011;
    fill_accessed = 4'b0011; fill_rsvd = 4'b1100; fill_dirty = 1'b1; fill_mtype = 3'd5;
    fire_fill();
    eq("R4 unused levels not refused", 64'(pre_refused), 64'd0);
    look(36'h202, 1'b1, 40'h13, "R4 short walk hit");
    eq("R4 write ignores unused", 64'(lk_write), 64'd1);
    eq("R4 user ignores unused", 64'(lk_user), 64'd1);
    eq("R4 dirty", 64'(lk_dirty), 64'd1);
    eq("R4 mtype", 64'(lk_mtype), 64'd5);
    nxe_en = 1'b1;
    prep(36'h203, 40'h14); fill_xd = 4'b0100;
    fire_fill();
    look(36'h203, 1'b1, 40'h14, "R3 fill taken");
    eq("R3 xd OR", 64'(lk_xd), 64'd1);
    prep(36'h204, 40'h15); fill_leaf_lvl = 2'd1; fill_xd = 4'b1100;
    fire_fill();
    look(36'h204, 1'b1, 40'h15, "R4 fill taken");
    eq("R4 xd ignores unused", 64'(lk_xd), 64'd0);
    nxe_en = 1'b0;
    prep(36'h205, 40'h16); fill_xd = 4'b0001;
    fire_fill();
    look(36'h205, 1'b1, 40'h16, "R3 fill taken");
    eq("R3 xd gated off", 64'(lk_xd), 64'd0);
  endtask

  task automatic t_refuse();
    do_inv(1'b1, '0);
    prep(36'h300, 40'h20); fill_present = 4'b1110;
    fire_fill();
    eq("R5 not present refused", 64'(pre_refused), 64'd1);
    eq("R5 no acc req", 64'(pre_acc), 64'd0);
    look(36'h300, 1'b0, '0, "R5 not cached");
    prep(36'h301, 40'h21); fill_rsvd = 4'b0100;
    fire_fill();
    eq("R5 reserved refused", 64'(pre_refused), 64'd1);
    look(36'h301, 1'b0, '0, "R5 not cached");
    prep(36'h302, 40'h22); fill_accessed = 4'b1010;
    fire_fill();
    eq("R6 acc req levels", 64'(pre_acc), 64'b0101);
    eq("R6 refused", 64'(pre_refused), 64'd1);
    look(36'h302, 1'b0, '0, "R6 not cached");
    prep(36'h303, 40'h23); fill_accessed = 4'b0110; fill_present = 4'b1110;
    fire_fill();
    eq("R6 no req on bad walk", 64'(pre_acc), 64'd0);
    prep(36'h302, 40'h22);
    fire_fill();
    eq("R6 retry accepted", 64'(pre_refused), 64'd0);
    look(36'h302, 1'b1, 40'h22, "R6 cached after retry");
  endtask

  task automatic t_replace();
    do_inv(1'b1, '0);
    for (int k = 0; k < 8; k++) begin
      prep(36'h400 + 36'(k), 40'h1000 + 40'(k));
      fire_fill();
    end
    prep(36'h403, 40'h2222);
    fire_fill();
    for (int k = 0; k < 8; k++)
      look(36'h400 + 36'(k), 1'b1, (k == 3) ? 40'h2222 : 40'h1000 + 40'(k), "R7 overwrite in place");
    prep(36'h500, 40'h3000);
    fire_fill();
    look(36'h400, 1'b0, '0, "R8 slot 0 evicted");
    look(36'h401, 1'b1, 40'h1001, "R8 slot 1 kept");
    look(36'h500, 1'b1, 40'h3000, "R8 new entry");
    prep(36'h501, 40'h3001);
    fire_fill();
    look(36'h401, 1'b0, '0, "R8 slot 1 evicted next");
    do_inv(1'b0, 36'h405);
    look(36'h405, 1'b0, '0, "R9 single removed");
    prep(36'h502, 40'h3002);
    fire_fill();
    look(36'h402, 1'b1, 40'h1002, "R8 free slot preferred");
    look(36'h502, 1'b1, 40'h3002, "R8 free slot used");
  endtask

  task automatic t_inv();
    do_inv(1'b1, '0);
    prep(36'h600, 40'h40); fire_fill();
    prep(36'h601, 40'h41); fire_fill();
    do_inv(1'b0, 36'h600);
    look(36'h600, 1'b0, '0, "R9 single target gone");
    look(36'h601, 1'b1, 40'h41, "R9 neighbour kept");
    do_inv(1'b1, '0);
    look(36'h601, 1'b0, '0, "R9 flush all");
  endtask

  task automatic t_collide();
    do_inv(1'b1, '0);
    prep(36'h700, 40'h1); fire_fill();
    prep(36'h700, 40'h2);
    collide(1'b0, 36'h700);
    eq("R10 ready low same page", 64'(pre_ready), 64'd0);
    look(36'h700, 1'b0, '0, "R10 invalidate wins");
    prep(36'h710, 40'h4); fire_fill();
    prep(36'h711, 40'h5);
    collide(1'b0, 36'h710);
    eq("R10 ready high other page", 64'(pre_ready), 64'd1);
    look(36'h711, 1'b1, 40'h5, "R10 fill lands");
    look(36'h710, 1'b0, '0, "R10 other page removed");
    prep(36'h712, 40'h6);
    collide(1'b1, '0);
    eq("R10 ready low on flush", 64'(pre_ready), 64'd0);
    look(36'h712, 1'b0, '0, "R10 flush drops fill");
    look(36'h711, 1'b0, '0, "R10 flush clears");
  endtask

  task automatic t_reset_late();
    prep(36'h800, 40'h9); fire_fill();
    look(36'h800, 1'b1, 40'h9, "R11 present before reset");
    do_reset();
    look(36'h800, 1'b0, '0, "R11 cleared by reset");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_merge();
    t_refuse();
    t_replace();
    t_inv();
    t_collide();
    t_reset_late();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule